// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of several DMA channels gets the transfer engine next. Each channel raises a request line. A per-channel enable bit gates that line. While the arbiter is idle it picks one winner among the enabled requests and issues a one-hot grant at the next clock edge. It holds that grant, and raises a busy flag, until the transfer sequencer pulses a service-complete strobe. The arbiter never pre-empts a grant.

A single mode input selects how the winner is found. In fixed mode the lowest-numbered channel always wins. In rotating mode the channel that was serviced last drops to the bottom of the order, and its circular successor moves to the top. In rotating mode no requester can be starved. Register programming, address and count logic, and bus strobe timing belong to other blocks.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While reset (`rst_n` low) is asserted and at the first edge after it, `grant` is all zero and `busy` is 0. After reset the rotating search starts at channel 0.
- R2: A channel whose `chan_en` bit is 0 is never granted, even if its `req` bit is 1.
- R3: `grant` is one-hot or all zero at every cycle. `busy` is 1 exactly when `grant` is nonzero.
- R4: When the arbiter is idle and at least one enabled request is present at a rising edge, `grant` and `busy` are set at that same edge.
- R5: With `rotate_mode` = 0 at the arbitration edge, the lowest-indexed enabled requester wins (channel 0 highest, channel N-1 lowest).
- R6: With `rotate_mode` = 1 at the arbitration edge, the search starts at the channel after the one most recently completed, wrapping from N-1 to 0, and takes the first enabled requester.
- R7: In rotating mode, a channel that keeps its enabled request asserted is granted after at most N-1 grants to other channels.
- R8: While `busy` is 1 and `svc_done` is 0, `grant` stays unchanged, whatever `req`, `chan_en` or `rotate_mode` do.
- R9: `svc_done` while busy clears `grant` and `busy` at that edge. No new grant is issued in the same edge, so the earliest next grant comes one edge later.
- R10: `svc_done` while idle has no effect: neither the outputs nor the rotation start point change.
- R11: Every completion moves the rotation start point to the successor of the completed channel, including completions that occur in fixed mode. The value of `rotate_mode` at each arbitration edge selects the scheme used for that decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_CH | Request line per channel |
| chan_en | input | NUM_CH | Enable bit per channel; 0 masks that request |
| rotate_mode | input | 1 | 1 = rotating priority, 0 = fixed priority |
| svc_done | input | 1 | Service-complete strobe for the granted channel |
| grant | output | NUM_CH | One-hot grant, all zero when idle |
| busy | output | 1 | A grant is outstanding |

## Verification
The hardest situation to reach is a rotation start point that was moved by a completion in fixed mode and then consumed after a switch to rotating mode. The same applies to a completion strobe sent while idle that must leave that start point alone. Neither effect is visible until a later rotating decision with several enabled requesters. The stimulus therefore toggles the mode bit and fires stray strobes during long random runs. A behavioural model tracks the expected start point and compares the grant every cycle. A directed phase also holds all requests high in rotating mode and counts the grants each waiting channel sees before it is served.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    PRIO_FIXED  = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;
endpackage

// File: rtl/dma_arb_reqmask.sv
module dma_arb_reqmask #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] chan_en,
  output logic [NUM_CH-1:0] masked,
  output logic              any_req
);
  assign masked  = req & chan_en;
  assign any_req = |masked;
endmodule

// File: rtl/dma_arb_select.sv
module dma_arb_select #(
  parameter int NUM_CH = 4,
  parameter int IDXW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] masked,
  input  logic [IDXW-1:0]   top,
  output logic [NUM_CH-1:0] win_oh,
  output logic [IDXW-1:0]   win_idx,
  output logic              found
);
  // circular search from 'top'; returns {found, index}
  function automatic logic [IDXW:0] pick(input logic [NUM_CH-1:0] m,
                                         input logic [IDXW-1:0] start);
    logic          hit;
    logic [IDXW-1:0] idx;
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      int c;
      c = (int'(start) + k) % NUM_CH;
      if (!hit && m[c]) begin
        hit = 1'b1;
        idx = IDXW'(c);
      end
    end
    return {hit, idx};
  endfunction

  logic [IDXW:0] result;
  assign result  = pick(masked, top);
  assign found   = result[IDXW];
  assign win_idx = result[IDXW-1:0];
  assign win_oh  = found ? (NUM_CH'(1) << win_idx) : '0;
endmodule

// File: rtl/dma_arb_rotptr.sv
module dma_arb_rotptr #(
  parameter int NUM_CH = 4,
  parameter int IDXW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic [IDXW-1:0] served_idx,
  output logic [IDXW-1:0] top_ptr
);
  function automatic logic [IDXW-1:0] successor(input logic [IDXW-1:0] i);
    return (int'(i) == NUM_CH - 1) ? '0 : IDXW'(int'(i) + 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       top_ptr <= '0;
    else if (advance) top_ptr <= successor(served_idx);
  end

  // R10 / R11: start point moves only on a completion
  a_r10_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(top_ptr));
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic              rotate_mode,
  input  logic              svc_done,
  output logic [NUM_CH-1:0] grant,
  output logic              busy
);
  import dma_arb_pkg::*;
  localparam int IDXW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] masked;
  logic              any_req;
  logic [IDXW-1:0]   rot_top, search_top, win_idx, gidx_q;
  logic [NUM_CH-1:0] win_oh, grant_q;
  logic              win_found, busy_q;
  prio_mode_e        mode;

  assign mode       = prio_mode_e'(rotate_mode);
  assign search_top = (mode == PRIO_ROTATE) ? rot_top : '0;

  // named internal events
  logic complete_evt, launch_evt;
  assign complete_evt = busy_q && svc_done;
  assign launch_evt   = !busy_q && win_found;

  dma_arb_reqmask #(.NUM_CH(NUM_CH)) u_mask (
    .req(req), .chan_en(chan_en), .masked(masked), .any_req(any_req));

  dma_arb_select #(.NUM_CH(NUM_CH), .IDXW(IDXW)) u_sel (
    .masked(masked), .top(search_top), .win_oh(win_oh),
    .win_idx(win_idx), .found(win_found));

  dma_arb_rotptr #(.NUM_CH(NUM_CH), .IDXW(IDXW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .advance(complete_evt),
    .served_idx(gidx_q), .top_ptr(rot_top));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      busy_q  <= 1'b0;
      gidx_q  <= '0;
    end else if (complete_evt) begin
      grant_q <= '0;
      busy_q  <= 1'b0;
    end else if (launch_evt) begin
      grant_q <= win_oh;
      busy_q  <= 1'b1;
      gidx_q  <= win_idx;
    end
  end

  assign grant = grant_q;
  assign busy  = busy_q;

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (busy == (grant != '0)));
  a_r4_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && any_req) |=> busy);
  a_r2_masked_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ((grant & $past(masked)) != '0));
  a_r5_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(rotate_mode)) |-> (($past(masked) & (grant - NUM_CH'(1))) == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !svc_done) |=> (busy && $stable(grant)));
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && svc_done) |=> !busy);
endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;
  localparam int N = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, chan_en = '0, grant;
  logic rotate_mode = 1'b0, svc_done = 1'b0, busy;

  int checks = 0, errors = 0, cycles = 0;

  // reference model state
  bit m_busy = 0;
  int m_gidx = -1;
  int m_top  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prio_arbiter #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .chan_en(chan_en),
    .rotate_mode(rotate_mode), .svc_done(svc_done),
    .grant(grant), .busy(busy));

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
        finish_run();
      end
    end
  end

  function automatic logic [N-1:0] exp_grant();
    return m_busy ? (N'(1) << m_gidx) : '0;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (grant !== exp_grant() || busy !== m_busy) begin
      errors++;
      $display("FAIL %s: actual grant=%b busy=%b expected grant=%b busy=%b",
               tag, grant, busy, exp_grant(), m_busy);
    end
  endtask

  // one clock: inputs applied at negedge, model advanced, compare after edge
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] e,
                      input logic rm, input logic sd);
    string tag;
    @(negedge clk);
    req = r; chan_en = e; rotate_mode = rm; svc_done = sd;
    if (m_busy) begin
      if (sd) begin
        tag = "R9";
        m_top = (m_gidx + 1) % N;
        m_busy = 0; m_gidx = -1;
      end else tag = "R8";
    end else begin
      int start, w;
      start = rm ? m_top : 0;
      w = -1;
      for (int k = 0; k < N; k++) begin
        int c;
        c = (start + k) % N;
        if (w < 0 && r[c] && e[c]) w = c;
      end
      if (w >= 0) begin
        tag = rm ? "R6" : "R5";
        m_busy = 1; m_gidx = w;
      end else tag = sd ? "R10" : "R2";
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req = '0; chan_en = '0; svc_done = 0;
    m_busy = 0; m_gidx = -1; m_top = 0;
    #1 compare("R1");
    @(posedge clk); #1 compare("R1");
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    do_reset();
    // R1: rotating search starts at channel 0 after reset
    step('1, '1, 1, 0);
    checks++;
    if (grant !== 4'b0001) begin errors++;
      $display("FAIL R1: actual=%b expected=0001", grant); end
    step('1, '1, 1, 1);
    // R9: no grant in the release edge, grant one edge later (R4)
    step('1, '1, 1, 0);
    checks++;
    if (grant !== 4'b0010) begin errors++;
      $display("FAIL R4/R6: actual=%b expected=0010", grant); end
    // R8: hold while inputs change
    step(4'b0001, 4'b0001, 0, 0);
    step('0, '0, 1, 0);
    checks++;
    if (grant !== 4'b0010) begin errors++;
      $display("FAIL R8: actual=%b expected=0010", grant); end
    step('0, '0, 0, 1);
    // R2: disabled requester ignored
    step(4'b0011, 4'b0010, 0, 0);
    checks++;
    if (grant !== 4'b0010) begin errors++;
      $display("FAIL R2: actual=%b expected=0010", grant); end
    step('0, '1, 0, 1);
    // R10: stray completion while idle; R11: last completion was ch1 in fixed mode
    step('0, '1, 0, 1);
    step('0, '1, 0, 1);
    step('1, '1, 1, 0);
    checks++;
    if (grant !== 4'b0100) begin errors++;
      $display("FAIL R11/R10: actual=%b expected=0100", grant); end
    step('1, '1, 1, 1);
    // R5: fixed picks lowest
    step(4'b1100, '1, 0, 0);
    checks++;
    if (grant !== 4'b0100) begin errors++;
      $display("FAIL R5: actual=%b expected=0100", grant); end
    step('0, '1, 0, 1);

    // R7: fairness with all requests held in rotating mode
    begin
      int waits[N];
      for (int i = 0; i < N; i++) waits[i] = 0;
      for (int n = 0; n < 40; n++) begin
        step('1, '1, 1, 0);
        for (int i = 0; i < N; i++) begin
          if (grant[i]) begin
            checks++;
            if (waits[i] > N - 1) begin errors++;
              $display("FAIL R7: actual wait=%0d expected<=%0d", waits[i], N-1); end
            waits[i] = 0;
          end else waits[i]++;
        end
        step('1, '1, 1, 0);
        step('1, '1, 1, 1);
      end
    end

    // random mix: every cycle compared (R3, R8..R11)
    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] r, e;
      r = N'($urandom);
      e = ($urandom % 4 == 0) ? N'($urandom) : '1;
      step(r, e, ($urandom % 8) < 4, ($urandom % 10) < 3);
    end

    do_reset();
    step('0, '0, 0, 0);
    finish_run();
  end
endmodule